// File: doc/BRIEF.md
# Up-Down PWM Time Base

This block is the time base of a center-aligned PWM channel. A counter climbs from zero to a programmable period value, turns, and descends back to zero, so one full PWM cycle lasts twice the period in clocks. The period is written into a shadow register. It only reaches the active copy, which the turn-around logic uses, at the moment the counter sits at zero. A period change therefore never tears a cycle that is already running.

Several instances can be chained. A sync input can reload the counter from a phase register when phase loading is enabled. A selectable sync output either flags each zero crossing or forwards the incoming sync within the same cycle. A master set to emit its zero event can then align a string of followers, each of which passes the pulse on. Outputs are the count, the direction flag, and one-clock strobes for the zero and period points. Configuration uses a single-cycle write port.

Top module: `updown_timebase`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets the counter to 0 and the direction flag to up (dir_down=0). It also clears the shadow period, active period, phase value and both control bits.
- R2: With a nonzero active period P and no sync load, the counter steps 0,1,…,P,P-1,…,1,0,1,… in successive clocks. Each endpoint appears for exactly one clock, and zero recurs every 2P clocks (1200 clocks for P=600).
- R3: dir_down is 0 while the counter shows 1..P, including the clock at P. It is 1 while the counter shows P-1 down to 0, including the clock at 0. It changes only at the turn-around points.
- R4: Writes with wr_sel=0 load the shadow period one clock later. The active period takes the shadow value only at a clock edge where the counter is 0, so it stays stable while the counter is nonzero.
- R5: When phase_en (control bit 0) is 1 and sync_in is high at a clock edge, the counter loads the phase value (wr_sel=1) and the direction becomes up. This overrides normal counting. If the loaded value is at or above the active period, the counter turns down on the next clock.
- R6: When phase_en is 0, sync_in has no effect on the counter or direction.
- R7: Control bit 1 (sync_src, written with wr_sel=2) picks the sync output source. With 0, sync_out equals zero_evt. With 1, sync_out equals sync_in in the same cycle, and this does not depend on phase_en.
- R8: zero_evt is high exactly while the counter is 0. prd_evt is high exactly while counting up with a nonzero active period and the counter at or above it. In normal counting each strobe lasts one clock.
- R9: While the active period is 0 and no sync load occurs, the counter holds at 0 with direction up.
- R10: A write with wr_sel=3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 period shadow, 1 phase, 2 control, 3 none |
| wr_data | input | W | Write data; control uses bit 0 phase_en, bit 1 sync_src |
| sync_in | input | 1 | Incoming synchronization pulse |
| cnt | output | W | Current counter value |
| dir_down | output | 1 | 1 while the counter is descending |
| zero_evt | output | 1 | Counter-equals-zero strobe |
| prd_evt | output | 1 | Counter-at-period strobe |
| sync_out | output | 1 | Zero strobe or forwarded sync_in, per sync_src |

## Verification
The bench targets the turn-around points. A design that counts one value too far or too short, or that repeats an endpoint, shifts the zero events away from the 2P spacing. A period written mid-cycle must not take effect before the next zero, or the ramp would clip early. Sync pulses are sent both with phase loading disabled, where a leaky design would jump its count, and with it enabled at an arbitrary point in the ramp and with a phase above the period, where a design that kept the old direction or overshot would diverge. A zero period, an unused write select and a mid-run reset are also exercised to show that the counter parks at 0 and stray writes change nothing.

// File: rtl/updown_timebase.sv
module updown_timebase #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         sync_in,
  output logic [W-1:0] cnt,
  output logic         dir_down,
  output logic         zero_evt,
  output logic         prd_evt,
  output logic         sync_out
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] prd_shadow, prd_act, phase_reg;
  logic         phase_en, sync_src;
  logic         load, at_top;

  assign load     = phase_en & sync_in;
  assign zero_evt = (cnt == '0);
  assign at_top   = (prd_act != '0) && (cnt >= prd_act);
  assign prd_evt  = !dir_down && at_top;
  assign sync_out = sync_src ? sync_in : zero_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      prd_shadow <= '0;
      phase_reg  <= '0;
      phase_en   <= 1'b0;
      sync_src   <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: prd_shadow <= wr_data;
        2'd1: phase_reg  <= wr_data;
        2'd2: begin
          phase_en <= wr_data[0];
          sync_src <= wr_data[1];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           prd_act <= '0;
    else if (zero_evt) prd_act <= prd_shadow;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      dir_down <= 1'b0;
    end else if (load) begin
      cnt      <= phase_reg;
      dir_down <= 1'b0;
    end else if (prd_act == '0) begin
      cnt      <= '0;
      dir_down <= 1'b0;
    end else if (!dir_down) begin
      if (at_top) begin
        cnt      <= cnt - ONE;
        dir_down <= 1'b1;
      end else begin
        cnt <= cnt + ONE;
      end
    end else begin
      if (zero_evt) begin
        cnt      <= ONE;
        dir_down <= 1'b0;
      end else begin
        cnt <= cnt - ONE;
      end
    end
  end

endmodule

module updown_timebase_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         sync_in,
  input logic [W-1:0] cnt,
  input logic         dir_down,
  input logic         zero_evt,
  input logic         sync_out,
  input logic [W-1:0] prd_act,
  input logic [W-1:0] phase_reg,
  input logic         phase_en,
  input logic         sync_src
);

  p_reset_r1: assert property (@(posedge clk) rst |=> (cnt == '0) && !dir_down && (prd_act == '0));

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    !(phase_en && sync_in) && (prd_act != '0) && (cnt <= prd_act) |=>
      (cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) - 1'b1));

  p_zero_turn_r3: assert property (@(posedge clk) disable iff (rst)
    !(phase_en && sync_in) && (prd_act != '0) && (cnt == '0) && dir_down |=>
      !dir_down && (cnt == 1));

  p_active_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |=> $stable(prd_act));

  p_phase_load_r5: assert property (@(posedge clk) disable iff (rst)
    phase_en && sync_in |=> (cnt == $past(phase_reg)) && !dir_down);

  p_pass_sync_r7: assert property (@(posedge clk) disable iff (rst)
    sync_src |-> (sync_out == sync_in));

  p_zero_once_r8: assert property (@(posedge clk) disable iff (rst)
    zero_evt && !(phase_en && sync_in) && (prd_act != '0) |=> !zero_evt);

  p_park_r9: assert property (@(posedge clk) disable iff (rst)
    (prd_act == '0) && !(phase_en && sync_in) |=> (cnt == '0) && !dir_down);

endmodule

bind updown_timebase updown_timebase_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .sync_in(sync_in), .cnt(cnt), .dir_down(dir_down),
  .zero_evt(zero_evt), .sync_out(sync_out), .prd_act(prd_act),
  .phase_reg(phase_reg), .phase_en(phase_en), .sync_src(sync_src)
);

// File: tb/updown_timebase_test.sv
module updown_timebase_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_sel = '0;
  logic [W-1:0] wr_data = '0;
  logic         sync_in = 1'b0;
  logic [W-1:0] cnt;
  logic         dir_down, zero_evt, prd_evt, sync_out;

  always #2.5 clk = ~clk;

  updown_timebase #(.W(W)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sync_in(sync_in), .cnt(cnt), .dir_down(dir_down), .zero_evt(zero_evt),
    .prd_evt(prd_evt), .sync_out(sync_out)
  );

  int checks = 0, fails = 0;
  int m_cnt = 0, m_dir = 0, m_shd = 0, m_act = 0, m_ph = 0, m_pen = 0, m_src = 0;
  int cyc = 0, last_zero = -1, gap = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  task automatic compare();
    int ez, ep, es;
    ez = (m_cnt == 0);
    ep = (m_dir == 0 && m_act != 0 && m_cnt >= m_act);
    es = m_src ? int'(sync_in) : ez;
    chk("R2", "cnt", int'(cnt), m_cnt);
    chk("R3", "dir_down", int'(dir_down), m_dir);
    chk("R8", "zero_evt", int'(zero_evt), ez);
    chk("R8", "prd_evt", int'(prd_evt), ep);
    chk("R7", "sync_out", int'(sync_out), es);
  endtask

  task automatic model_edge();
    int nc, nd;
    if (rst) begin
      m_cnt = 0; m_dir = 0; m_shd = 0; m_act = 0; m_ph = 0; m_pen = 0; m_src = 0;
      return;
    end
    if (m_pen && sync_in) begin nc = m_ph; nd = 0; end
    else if (m_act == 0) begin nc = 0; nd = 0; end
    else if (m_dir == 0) begin
      if (m_cnt >= m_act) begin nc = m_cnt - 1; nd = 1; end
      else begin nc = m_cnt + 1; nd = 0; end
    end else begin
      if (m_cnt == 0) begin nc = 1; nd = 0; end
      else begin nc = m_cnt - 1; nd = 1; end
    end
    if (m_cnt == 0) m_act = m_shd;
    if (wr_en) begin
      case (wr_sel)
        2'd0: m_shd = int'(wr_data);
        2'd1: m_ph = int'(wr_data);
        2'd2: begin m_pen = int'(wr_data[0]); m_src = int'(wr_data[1]); end
        default: ;
      endcase
    end
    m_cnt = nc; m_dir = nd;
  endtask

  task automatic step(input bit r, input bit we, input int sel, input int data, input bit s);
    rst = r; wr_en = we; wr_sel = 2'(sel); wr_data = W'(data); sync_in = s;
    #1;
    compare();
    if (!r && zero_evt) begin
      if (last_zero >= 0) gap = cyc - last_zero;
      last_zero = cyc;
    end
    @(posedge clk);
    model_edge();
    cyc++;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  initial begin
    int t;
    @(negedge clk);
    // R1: reset state
    step(1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    chk("R1", "cnt after reset", int'(cnt), 0);
    chk("R1", "dir after reset", int'(dir_down), 0);

    // R9: zero period parks the counter
    idle(4);
    chk("R9", "parked cnt", int'(cnt), 0);

    // R2/R3: period 5
    step(0, 1, 0, 5, 0);
    idle(40);

    // R4: shadow change mid-ramp applied only at zero
    while (cnt != 3) step(0, 0, 0, 0, 0);
    step(0, 1, 0, 3, 0);
    idle(6);
    idle(20);

    // R6: sync ignored with phase loading off (control bit0 = 0)
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 1);
    idle(3);

    // R7: pass-through sync (control = 2'b10)
    step(0, 1, 2, 2, 0);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1);
    idle(4);

    // R5: phase load with phase 0 mid-ramp, then phase above period
    step(0, 1, 1, 0, 0);
    step(0, 1, 2, 1, 0);
    idle(2);
    step(0, 0, 0, 0, 1);
    chk("R5", "cnt after load", int'(cnt), 0);
    idle(5);
    step(0, 1, 1, 7, 0);
    step(0, 0, 0, 0, 1);
    chk("R5", "cnt after high phase", int'(cnt), 7);
    idle(12);
    step(0, 1, 2, 0, 0);

    // R10: unused select writes nothing
    step(0, 1, 3, 9, 0);
    idle(15);

    // R2: long period spacing of zero events
    step(0, 1, 0, 600, 0);
    gap = 0;
    for (t = 0; t < 2600; t++) step(0, 0, 0, 0, 0);
    chk("R2", "zero spacing for 600", gap, 1200);

    // R9: period back to 0, parks at next zero
    step(0, 1, 0, 0, 0);
    for (t = 0; t < 1300; t++) step(0, 0, 0, 0, 0);
    chk("R9", "parked after zero period", int'(cnt), 0);

    // R1: reset mid-run
    step(0, 1, 0, 4, 0);
    idle(7);
    step(1, 0, 0, 0, 0);
    chk("R1", "cnt after mid-run reset", int'(cnt), 0);
    idle(6);
    chk("R1", "registers cleared so counter parks", int'(cnt), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule